// File: doc/BRIEF.md
# Delayed Register-Indirect Jump Sequencer

This block holds the fetch program counter of a 64-bit RISC pipeline and carries out the register-indirect jump-and-link instruction. Each pulse of the advance strobe retires one instruction. A plain instruction moves the PC on by four bytes. When the retiring instruction is a register-indirect jump, the block takes the target from the source register's read data and keeps it in a holding register. It lets one more instruction (the delay slot) retire, and only then loads the target into the PC.

During the jump the block also emits a one-cycle register write. The write carries the return address, which is the address just past the delay slot. When compressed instruction support is enabled, the lowest bit of the target does not form part of the PC. That bit instead selects the instruction-set mode: 0 means 32-bit instructions and 1 means 16-bit instructions. The return address then records the mode that was in effect before the jump. A misaligned target is reported only when the PC reaches it, never when the jump retires.

Top module: `jumpSequencer`

## Requirements
- R1: An instruction is a jump only when bits 31:26 are 000000, bits 5:0 are 001001, bits 20:16 are zero and bits 10:6 are zero. The source register index is in bits 25:21 and the destination index is in bits 15:11. Any other word retires as a plain instruction.
- R2: After reset, fetchPc is 0, isaMode is 0, and wrEn, addrErr and nestedJump are all low.
- R3: On each advance pulse without a pending redirect, fetchPc increases by 4. While advance is low, fetchPc, isaMode and any pending redirect stay as they are.
- R4: The advance pulse that retires a jump moves fetchPc to the jump's address plus 4. The next advance pulse, which retires the delay slot, loads the target into fetchPc.
- R5: For the one clock after a jump retires, wrEn is high and wrAddr equals the destination field. An encoded destination of 31 behaves like any other. With compressed support disabled, wrData is the jump's address plus 8.
- R6: With compEn high when the jump retires, the target is the source data with bit 0 cleared, and isaMode takes source bit 0 when the redirect happens. wrData is the jump's address plus 8 with bit 0 replaced by the isaMode in effect before the jump.
- R7: With compEn low when the jump retires, the PC loads the source data unchanged and isaMode returns to 0 at the redirect.
- R8: addrErr is high while isaMode is 0 and fetchPc bits 1:0 are not 00, or while isaMode is 1 and fetchPc bit 0 is 1. Retiring a jump raises no error.
- R9: A jump that retires in a delay slot is ignored. It causes no register write and does not change the pending target, and nestedJump pulses high for one clock after it retires.
- R10: rsAddr always equals bits 25:21 of the presented instruction word. Source data and compEn are sampled on the jump's advance pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | One instruction retires on this clock |
| instr | input | 32 | Instruction word at fetchPc |
| compEn | input | 1 | Compressed instruction support enabled |
| rsAddr | output | 5 | Source register index to the register file |
| rsData | input | 64 | Register file read data for rsAddr |
| fetchPc | output | 64 | Current fetch program counter |
| isaMode | output | 1 | 0: 32-bit instructions, 1: 16-bit instructions |
| addrErr | output | 1 | fetchPc misaligned for the current mode |
| wrEn | output | 1 | Return-address write strobe |
| wrAddr | output | 5 | Destination register index |
| wrData | output | 64 | Return address |
| nestedJump | output | 1 | Jump in a delay slot was dropped |

## Verification
The bench targets the delay-slot timing. A design that redirected at once would show the target right after the jump instead of the jump's address plus 4. The bench also covers words that almost decode: a nonzero reserved field, or the plain jump-register function code, must retire as ordinary instructions, and a loose decoder would write a link register for them. In compressed mode it checks that the target has bit 0 stripped and that the return address carries the old mode rather than the new one. It also checks that turning compressed support off brings the mode back to 32-bit and that the misaligned PC then raises the fetch error. A second jump in the delay slot must not write a register or replace the held target, so a design that honoured it would land at the wrong address.

// File: rtl/jumpseq_pkg.sv
package jumpseq_pkg;
  // instruction field positions that the decoder depends on
  localparam int unsigned OPC_HI   = 31;
  localparam int unsigned OPC_LO   = 26;
  localparam int unsigned SRC_HI   = 25;
  localparam int unsigned SRC_LO   = 21;
  localparam int unsigned RSV0_HI  = 20;
  localparam int unsigned RSV0_LO  = 16;
  localparam int unsigned DST_HI   = 15;
  localparam int unsigned DST_LO   = 11;
  localparam int unsigned RSV1_HI  = 10;
  localparam int unsigned RSV1_LO  = 6;
  localparam int unsigned FUNC_HI  = 5;
  localparam int unsigned FUNC_LO  = 0;

  localparam logic [5:0] OPC_REGCLASS = 6'b000000;
  localparam logic [5:0] FUNC_JMPLINK = 6'b001001;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_SLOT = 1'b1
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;      // one instruction retires
    logic jump;      // a jump retires outside a delay slot
    logic redirect;  // the delay slot retires, load held target
  } seqCtrl_t;
endpackage

// File: rtl/jumpSeqCtrl.sv
module jumpSeqCtrl
  import jumpseq_pkg::*;
#(
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               advance,
  input  logic [INSTR_W-1:0] instr,
  output seqCtrl_t           ctrl,
  output logic               nestedJump
);

  seqState_e state;
  logic      isJump;
  logic      opcOk;
  logic      funcOk;
  logic      rsvOk;

  always_comb begin
    opcOk  = (instr[OPC_HI:OPC_LO] == OPC_REGCLASS);
    funcOk = (instr[FUNC_HI:FUNC_LO] == FUNC_JMPLINK);
    rsvOk  = (instr[RSV0_HI:RSV0_LO] == '0) && (instr[RSV1_HI:RSV1_LO] == '0);
    isJump = opcOk && funcOk && rsvOk;
  end

  always_comb begin
    ctrl.step     = advance;
    ctrl.jump     = advance && isJump && (state == SEQ_IDLE);
    ctrl.redirect = advance && (state == SEQ_SLOT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= SEQ_IDLE;
      nestedJump <= 1'b0;
    end else begin
      nestedJump <= advance && isJump && (state == SEQ_SLOT);
      if (ctrl.jump) begin
        state <= SEQ_SLOT;
      end else if (ctrl.redirect) begin
        state <= SEQ_IDLE;
      end
    end
  end

  // R4: a retired jump always opens a delay slot
  p_slot_opens_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.jump |=> (state == SEQ_SLOT));

  // R4: the slot closes on the next retirement
  p_slot_closes_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_SLOT && advance) |=> (state == SEQ_IDLE));

  // R9: the dropped-jump flag only follows a slot retirement
  p_nested_in_slot_r9: assert property (@(posedge clk) disable iff (!rstN)
    nestedJump |-> $past(state == SEQ_SLOT && advance));

endmodule

// File: rtl/jumpSeqData.sv
module jumpSeqData
  import jumpseq_pkg::*;
#(
  parameter int unsigned XLEN        = 64,
  parameter int unsigned REG_AW      = 5,
  parameter int unsigned INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic [REG_AW-1:0] srcField,
  input  logic [REG_AW-1:0] dstField,
  input  logic              compEn,
  input  logic [XLEN-1:0]   rsData,
  output logic [REG_AW-1:0] rsAddr,
  output logic [XLEN-1:0]   fetchPc,
  output logic              isaMode,
  output logic              addrErr,
  output logic              wrEn,
  output logic [REG_AW-1:0] wrAddr,
  output logic [XLEN-1:0]   wrData
);

  localparam int unsigned ALIGN_BITS = $clog2(INSTR_BYTES);
  localparam logic [XLEN-1:0] PC_STEP   = XLEN'(INSTR_BYTES);
  localparam logic [XLEN-1:0] LINK_SPAN = XLEN'(2 * INSTR_BYTES);

  logic [XLEN-1:0] heldTarget;
  logic            heldMode;
  logic [XLEN-1:0] nextTarget;
  logic            nextMode;
  logic [XLEN-1:0] pcPlusLink;
  logic [XLEN-1:0] linkValue;

  assign rsAddr = srcField;

  always_comb begin
    pcPlusLink = fetchPc + LINK_SPAN;
    if (compEn) begin
      nextTarget = {rsData[XLEN-1:1], 1'b0};
      nextMode   = rsData[0];
      linkValue  = {pcPlusLink[XLEN-1:1], isaMode};
    end else begin
      nextTarget = rsData;
      nextMode   = 1'b0;
      linkValue  = pcPlusLink;
    end
  end

  always_comb begin
    if (isaMode) begin
      addrErr = fetchPc[0];
    end else begin
      addrErr = |fetchPc[ALIGN_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPc    <= RESET_PC;
      isaMode    <= 1'b0;
      heldTarget <= '0;
      heldMode   <= 1'b0;
      wrEn       <= 1'b0;
      wrAddr     <= '0;
      wrData     <= '0;
    end else begin
      wrEn <= ctrl.jump;
      if (ctrl.jump) begin
        heldTarget <= nextTarget;
        heldMode   <= nextMode;
        wrAddr     <= dstField;
        wrData     <= linkValue;
      end
      if (ctrl.redirect) begin
        fetchPc <= heldTarget;
        isaMode <= heldMode;
      end else if (ctrl.step) begin
        fetchPc <= fetchPc + PC_STEP;
      end
    end
  end

  // R3: nothing moves while no instruction retires
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.step |=> ($stable(fetchPc) && $stable(isaMode)));

  // R3: a plain retirement advances by one instruction
  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step && !ctrl.redirect) |=> (fetchPc == $past(fetchPc) + PC_STEP));

  // R5: the return-address write is a single-cycle pulse
  p_wb_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R6: in 16-bit mode the PC never carries bit 0
  p_half_align_r6: assert property (@(posedge clk) disable iff (!rstN)
    isaMode |-> !fetchPc[0]);

endmodule

// File: rtl/jumpSequencer.sv
module jumpSequencer
  import jumpseq_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned REG_AW  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               advance,
  input  logic [INSTR_W-1:0] instr,
  input  logic               compEn,
  output logic [REG_AW-1:0]  rsAddr,
  input  logic [XLEN-1:0]    rsData,
  output logic [XLEN-1:0]    fetchPc,
  output logic               isaMode,
  output logic               addrErr,
  output logic               wrEn,
  output logic [REG_AW-1:0]  wrAddr,
  output logic [XLEN-1:0]    wrData,
  output logic               nestedJump
);

  localparam int unsigned INSTR_BYTES = INSTR_W / 8;

  seqCtrl_t ctrl;

  jumpSeqCtrl #(
    .INSTR_W(INSTR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .advance   (advance),
    .instr     (instr),
    .ctrl      (ctrl),
    .nestedJump(nestedJump)
  );

  jumpSeqData #(
    .XLEN       (XLEN),
    .REG_AW     (REG_AW),
    .INSTR_BYTES(INSTR_BYTES),
    .RESET_PC   ('0)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .srcField(instr[SRC_HI:SRC_LO]),
    .dstField(instr[DST_HI:DST_LO]),
    .compEn  (compEn),
    .rsData  (rsData),
    .rsAddr  (rsAddr),
    .fetchPc (fetchPc),
    .isaMode (isaMode),
    .addrErr (addrErr),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

endmodule

// File: tb/tb_jumpSequencer.sv
module tb_jumpSequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        advance = 1'b0;
  logic [31:0] instr = '0;
  logic        compEn = 1'b0;
  logic [4:0]  rsAddr;
  logic [63:0] rsData = '0;
  logic [63:0] fetchPc;
  logic        isaMode;
  logic        addrErr;
  logic        wrEn;
  logic [4:0]  wrAddr;
  logic [63:0] wrData;
  logic        nestedJump;

  int checks = 0;
  int fails = 0;
  logic [63:0] expPc = '0;
  logic        expMode = 1'b0;

  always #5 clk = ~clk;

  jumpSequencer dut (
    .clk(clk), .rstN(rstN), .advance(advance), .instr(instr), .compEn(compEn),
    .rsAddr(rsAddr), .rsData(rsData), .fetchPc(fetchPc), .isaMode(isaMode),
    .addrErr(addrErr), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .nestedJump(nestedJump)
  );

  function automatic logic [31:0] encJump(input logic [4:0] s, input logic [4:0] d);
    return {6'b000000, s, 5'b00000, d, 5'b00000, 6'b001001};
  endfunction

  function automatic logic expErr(input logic [63:0] pc, input logic m);
    return m ? pc[0] : (pc[1:0] != 2'b00);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic retire(input logic [31:0] w, input logic [63:0] src, input logic ce);
    @(negedge clk);
    instr = w; rsData = src; compEn = ce; advance = 1'b1;
    @(posedge clk); #1;
    advance = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic chkPc(input string req);
    chk(req, "fetchPc", fetchPc, expPc);
    chk(req, "isaMode", {63'd0, isaMode}, {63'd0, expMode});
    chk("R8", "addrErr", {63'd0, addrErr}, {63'd0, expErr(expPc, expMode)});
  endtask

  // full jump + delay slot against the bench model
  task automatic jumpSeq(input string req, input logic [4:0] s, input logic [4:0] d,
                         input logic [63:0] src, input logic ce);
    logic [63:0] p8;
    logic [63:0] link;
    logic [63:0] tgt;
    logic        newMode;
    p8   = expPc + 64'd8;
    link = ce ? {p8[63:1], expMode} : p8;
    tgt  = ce ? {src[63:1], 1'b0} : src;
    newMode = ce ? src[0] : 1'b0;
    @(negedge clk);
    instr = encJump(s, d); rsData = src; compEn = ce;
    #1;
    chk("R10", "rsAddr", {59'd0, rsAddr}, {59'd0, s});
    advance = 1'b1;
    @(posedge clk); #1;
    advance = 1'b0;
    expPc = expPc + 64'd4;
    chk("R4", "pc after jump", fetchPc, expPc);
    chk("R8", "no error at jump", {63'd0, addrErr}, {63'd0, expErr(expPc, expMode)});
    chk("R5", "wrEn", {63'd0, wrEn}, 64'd1);
    chk("R5", "wrAddr", {59'd0, wrAddr}, {59'd0, d});
    chk(req, "wrData", wrData, link);
    rsData = 64'hDEAD_BEEF_0000_0000;
    idle(2);
    chk("R5", "wrEn pulse", {63'd0, wrEn}, 64'd0);
    chk("R3", "held in slot", fetchPc, expPc);
    retire(32'h0, 64'h0, 1'b0);
    expPc = tgt; expMode = newMode;
    chkPc(req);
  endtask

  task automatic t_reset;
    chk("R2", "fetchPc", fetchPc, 64'd0);
    chk("R2", "isaMode", {63'd0, isaMode}, 64'd0);
    chk("R2", "wrEn", {63'd0, wrEn}, 64'd0);
    chk("R2", "addrErr", {63'd0, addrErr}, 64'd0);
    chk("R2", "nestedJump", {63'd0, nestedJump}, 64'd0);
  endtask

  task automatic t_sequential;
    for (int i = 0; i < 3; i++) begin
      retire(32'h0000_0020, 64'h0, 1'b0);
      expPc = expPc + 64'd4;
    end
    chkPc("R3");
    idle(3);
    chkPc("R3");
  endtask

  task automatic t_decodeReject;
    retire(encJump(5'd4, 5'd6) | 32'h0001_0000, 64'h9000, 1'b0);
    expPc = expPc + 64'd4;
    chkPc("R1");
    chk("R1", "no write rsv field", {63'd0, wrEn}, 64'd0);
    retire({6'b0, 5'd4, 5'd0, 5'd6, 5'd0, 6'b001000}, 64'h9000, 1'b0);
    expPc = expPc + 64'd4;
    chkPc("R1");
    chk("R1", "no write other func", {63'd0, wrEn}, 64'd0);
    retire(encJump(5'd4, 5'd6) | 32'h0000_0040, 64'h9000, 1'b0);
    expPc = expPc + 64'd4;
    chk("R1", "no write rsv field 2", {63'd0, wrEn}, 64'd0);
    retire(32'h0, 64'h0, 1'b0);
    expPc = expPc + 64'd4;
    chkPc("R1");
  endtask

  task automatic t_nested;
    logic [63:0] p8;
    p8 = expPc + 64'd8;
    retire(encJump(5'd3, 5'd3), 64'h8800, 1'b0);
    expPc = expPc + 64'd4;
    chk("R9", "first jump link", wrData, p8);
    retire(encJump(5'd9, 5'd12), 64'hC000, 1'b0);
    expPc = 64'h8800; expMode = 1'b0;
    chk("R9", "no write for slot jump", {63'd0, wrEn}, 64'd0);
    chk("R9", "nestedJump", {63'd0, nestedJump}, 64'd1);
    chkPc("R9");
    idle(1);
    chk("R9", "nestedJump pulse", {63'd0, nestedJump}, 64'd0);
    retire(32'h0, 64'h0, 1'b0);
    expPc = expPc + 64'd4;
    chkPc("R9");
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rstN = 1'b1;
    #1;
    t_reset();
    t_sequential();
    jumpSeq("R5", 5'd5, 5'd7, 64'h1000, 1'b0);
    jumpSeq("R5", 5'd2, 5'd31, 64'h2000, 1'b0);
    t_decodeReject();
    jumpSeq("R6", 5'd8, 5'd1, 64'h3001, 1'b1);
    retire(32'h0, 64'h0, 1'b1);
    expPc = expPc + 64'd4;
    chkPc("R6");
    jumpSeq("R6", 5'd8, 5'd1, 64'h4000, 1'b1);
    jumpSeq("R6", 5'd10, 5'd2, 64'h5001, 1'b1);
    jumpSeq("R7", 5'd11, 5'd2, 64'h6003, 1'b0);
    chk("R8", "misaligned target error", {63'd0, addrErr}, 64'd1);
    jumpSeq("R6", 5'd12, 5'd4, 64'h7002, 1'b1);
    chk("R8", "mode0 bit1 error", {63'd0, addrErr}, 64'd1);
    jumpSeq("R6", 5'd13, 5'd4, 64'h7007, 1'b1);
    chk("R8", "16-bit aligned ok", {63'd0, addrErr}, 64'd0);
    jumpSeq("R7", 5'd14, 5'd4, 64'h8000, 1'b0);
    t_nested();
    finishRun();
  end
endmodule